// File: doc/BRIEF.md
# Monotone-Sum Parametric Conjunctor

This combinational block computes a fuzzy conjunction `z = T(x, y)` on integer truth values in `0..n`. A threshold `p` splits the input square into four sectors. Each sector takes its own basic t-norm from a per-sector 3-bit selector. The block decides which sector the operand pair falls into and passes that sector's selector to a single shared basic t-norm evaluator. The evaluator always works on the raw operands over the full domain `0..n`, and never shifts them by `p`.

A 2-bit mode input picks between non-commutative operation (modes 0 and 1) and commutative operation (modes 2 and 3). In commutative modes the selector for the "x below, y at-or-above" sector is ignored and the "x at-or-above, y below" selector is used for both off-diagonal sectors. The user must choose selectors that satisfy the usual ordering between sectors if a true conjunctor is wanted. The hardware computes whatever the selectors ask for and does not check the ordering.

Top module: `fzc_monotone_conj`

## Requirements
- R1: When `x_in < thr_in` and `y_in < thr_in`, `z_out` equals the basic t-norm chosen by `tsel_ll` applied to `(x_in, y_in)`.
- R2: When `y_in < thr_in <= x_in`, `z_out` equals the basic t-norm chosen by `tsel_hl`.
- R3: When `x_in < thr_in <= y_in` and `mode_in` is 0 or 1, `z_out` equals the basic t-norm chosen by `tsel_lh`.
- R4: When `mode_in` is 2 or 3, `tsel_lh` has no effect: the sector `x_in < thr_in <= y_in` uses `tsel_hl`. With commutative basic t-norms selected, `z_out(x,y) = z_out(y,x)`.
- R5: When `thr_in = 0`, `z_out` equals the t-norm chosen by `tsel_hh` over the whole square.
- R6: When `thr_in = top_in = n`, `z_out` equals the t-norm chosen by `tsel_ll` over the whole square `0..n`.
- R7: Selector codes, with `I = top_in` and sums formed without overflow: 0 drastic (`x` if `y=I`, else `y` if `x=I`, else 0); 1 bounded difference `max(x+y-I, 0)`; 2 nilpotent minimum (`min(x,y)` if `x+y>I`, else 0); 3 minimum; 4 normalised product `floor(x*y/I)` (0 when `I=0`); codes 5 to 7 act as minimum.
- R8: For operands in `0..n`, `z_out(x, n) = x` and `z_out(n, y) = y` for every selector choice and mode.
- R9: For operands in `0..n`, `z_out <= min(x_in, y_in)`, and `z_out = 0` whenever either operand is 0.
- R10: A selector set that breaks the ordering between sectors is still evaluated sector by sector, without correction.
- R11: When `thr_in <= x_in` and `thr_in <= y_in`, `z_out` equals the basic t-norm chosen by `tsel_hh`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | W | first operand, 0..n |
| y_in | input | W | second operand, 0..n |
| thr_in | input | W | sector threshold p |
| top_in | input | W+1 | domain maximum n (the value read as "fully true") |
| mode_in | input | 2 | 0/1 non-commutative, 2/3 commutative |
| tsel_ll | input | 3 | t-norm code for both operands below p |
| tsel_hl | input | 3 | t-norm code for x at-or-above p, y below |
| tsel_lh | input | 3 | t-norm code for x below p, y at-or-above |
| tsel_hh | input | 3 | t-norm code for both operands at-or-above p |
| z_out | output | W | conjunction result |

## Verification
The sweeps place the threshold at 0, at 1, in the interior, one below the top, and at the top, and they use two domain sizes. This catches a decode that is off by one at `x = p`: such a design would apply the lower sector's t-norm on the threshold row and column, and the sector-wise comparison would miss there. The commutative modes are checked against the swapped operand pair, with a deliberately different `tsel_lh`. A design that still read that selector would break symmetry and mismatch in the `x < p <= y` sector. The top-row and top-column identity checks, together with the zero-operand checks, expose a bounded-difference or product evaluator that overflows or truncates its `m+1`-bit arithmetic, and a drastic evaluator that compares against the wrong maximum. An ordering-violating selector set confirms that nothing tries to repair the user's choice.

// File: rtl/fzc_pkg.sv
package fzc_pkg;

    // Basic t-norm codes; values 5..7 are treated as minimum.
    typedef enum logic [2:0] {
        TN_DRASTIC = 3'd0,
        TN_LUKAS   = 3'd1,
        TN_NILMIN  = 3'd2,
        TN_MIN     = 3'd3,
        TN_PROD    = 3'd4
    } tnorm_e;

    // Sector index {x >= p, y >= p}.
    typedef enum logic [1:0] {
        SEC_LOLO = 2'b00,
        SEC_LOHI = 2'b01,
        SEC_HILO = 2'b10,
        SEC_HIHI = 2'b11
    } sector_e;

endpackage

// File: rtl/fzc_sector_decode.sv
module fzc_sector_decode
    import fzc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] thr,
    output sector_e      sec
);

    logic a_hi;
    logic b_hi;

    always_comb begin
        a_hi = (a >= thr);
        b_hi = (b >= thr);
        sec  = sector_e'({a_hi, b_hi});
    end

    // A zero threshold leaves only the upper-right sector.
    always_comb begin
        if (thr == '0) begin
            assert_p0_single_sector_R5: assert (sec == SEC_HIHI)
                else $error("threshold zero decoded outside upper sector");
        end
    end

endmodule

// File: rtl/fzc_basic_tnorm.sv
module fzc_basic_tnorm
    import fzc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W:0]   top,
    input  logic [2:0]   kind,
    output logic [W-1:0] z
);

    localparam int XW = W + 1;
    localparam int PW = 2 * W;

    logic [XW-1:0] sum;
    logic [W-1:0]  lo;
    logic [PW-1:0] mul;
    logic [PW-1:0] quo;

    always_comb begin
        sum = {1'b0, a} + {1'b0, b};
        lo  = (a < b) ? a : b;
        mul = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        quo = (top == '0) ? '0 : (mul / {{(PW-XW){1'b0}}, top});

        case (kind)
            TN_DRASTIC: begin
                if ({1'b0, b} == top)      z = a;
                else if ({1'b0, a} == top) z = b;
                else                       z = '0;
            end
            TN_LUKAS:  z = (sum >= top) ? W'(sum - top) : '0;
            TN_NILMIN: z = (sum > top) ? lo : '0;
            TN_PROD:   z = W'(quo);
            default:   z = lo;
        endcase
    end

endmodule

// File: rtl/fzc_monotone_conj.sv
module fzc_monotone_conj
    import fzc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic [W-1:0] thr_in,
    input  logic [W:0]   top_in,
    input  logic [1:0]   mode_in,
    input  logic [2:0]   tsel_ll,
    input  logic [2:0]   tsel_hl,
    input  logic [2:0]   tsel_lh,
    input  logic [2:0]   tsel_hh,
    output logic [W-1:0] z_out
);

    sector_e    sec;
    logic       sym_mode;
    logic [2:0] kind;

    fzc_sector_decode #(.W(W)) u_decode (
        .a   (x_in),
        .b   (y_in),
        .thr (thr_in),
        .sec (sec)
    );

    always_comb begin
        sym_mode = (mode_in == 2'd2) || (mode_in == 2'd3);
        kind     = tsel_hh;
        case (sec)
            SEC_LOLO: kind = tsel_ll;
            SEC_HILO: kind = tsel_hl;
            SEC_LOHI: kind = sym_mode ? tsel_hl : tsel_lh;
            default:  kind = tsel_hh;
        endcase
    end

    fzc_basic_tnorm #(.W(W)) u_tnorm (
        .a    (x_in),
        .b    (y_in),
        .top  (top_in),
        .kind (kind),
        .z    (z_out)
    );

    // Output-level properties of any conjunction built from basic t-norms.
    always_comb begin
        if (({1'b0, x_in} <= top_in) && ({1'b0, y_in} <= top_in)) begin
            assert_range_R9: assert (z_out <= ((x_in < y_in) ? x_in : y_in))
                else $error("result above operand minimum");
            if ((x_in == '0) || (y_in == '0)) begin
                assert_zero_R9: assert (z_out == '0)
                    else $error("zero operand gave nonzero result");
            end
            if ({1'b0, y_in} == top_in) begin
                assert_ident_y_R8: assert (z_out == x_in)
                    else $error("top y operand is not an identity");
            end
            if ({1'b0, x_in} == top_in) begin
                assert_ident_x_R8: assert (z_out == y_in)
                    else $error("top x operand is not an identity");
            end
        end
    end

endmodule

// File: tb/fzc_monotone_conj_tb.sv
module fzc_monotone_conj_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] x_in = '0;
    logic [W-1:0] y_in = '0;
    logic [W-1:0] thr_in = '0;
    logic [W:0]   top_in = '0;
    logic [1:0]   mode_in = '0;
    logic [2:0]   tsel_ll = '0;
    logic [2:0]   tsel_hl = '0;
    logic [2:0]   tsel_lh = '0;
    logic [2:0]   tsel_hh = '0;
    logic [W-1:0] z_out;

    int n_vec  = 0;
    int n_miss = 0;
    int cyc    = 0;

    always #10 clk = ~clk;   // 50 MHz

    fzc_monotone_conj #(.W(W)) u_dut (
        .x_in    (x_in),
        .y_in    (y_in),
        .thr_in  (thr_in),
        .top_in  (top_in),
        .mode_in (mode_in),
        .tsel_ll (tsel_ll),
        .tsel_hl (tsel_hl),
        .tsel_lh (tsel_lh),
        .tsel_hh (tsel_hh),
        .z_out   (z_out)
    );

    // Selector sets {ll, hl, lh, hh}; set 5 breaks the sector ordering.
    int s_ll[6] = '{0, 0, 1, 2, 4, 3};
    int s_hl[6] = '{0, 1, 4, 2, 7, 0};
    int s_lh[6] = '{0, 2, 2, 2, 5, 1};
    int s_hh[6] = '{0, 3, 3, 3, 6, 0};

    function automatic int mn(int a, int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int tn(int code, int a, int b, int n);
        case (code)
            0: return (b == n) ? a : ((a == n) ? b : 0);
            1: return (a + b >= n) ? (a + b - n) : 0;
            2: return (a + b > n) ? mn(a, b) : 0;
            4: return (n == 0) ? 0 : (a * b) / n;
            default: return mn(a, b);
        endcase
    endfunction

    function automatic int model(int a, int b, int p, int n, int md, int k);
        if (a < p && b < p)   return tn(s_ll[k], a, b, n);
        if (b < p)            return tn(s_hl[k], a, b, n);
        if (a < p)            return tn((md >= 2) ? s_hl[k] : s_lh[k], a, b, n);
        return tn(s_hh[k], a, b, n);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_miss++;
            $display("FAIL %s x=%0d y=%0d p=%0d n=%0d mode=%0d actual=%0d expected=%0d",
                     tag, x_in, y_in, thr_in, top_in, mode_in, act, exp);
        end
    endtask

    task automatic sweep(int n, int p, int md, int k);
        thr_in  = W'(p);
        top_in  = (W+1)'(n);
        mode_in = 2'(md);
        tsel_ll = 3'(s_ll[k]);
        tsel_hl = 3'(s_hl[k]);
        tsel_lh = 3'(s_lh[k]);
        tsel_hh = 3'(s_hh[k]);
        for (int x = 0; x <= n; x++) begin
            for (int y = 0; y <= n; y++) begin
                string tag;
                @(posedge clk);
                x_in = W'(x);
                y_in = W'(y);
                @(negedge clk);
                if (k == 5)                 tag = "R10";
                else if (x < p && y < p)    tag = "R1 R7";
                else if (y < p)             tag = "R2 R7";
                else if (x < p)             tag = (md >= 2) ? "R4 R7" : "R3 R7";
                else                        tag = "R11 R7";
                chk(tag, int'(z_out), model(x, y, p, n, md, k));
                if (p == 0) chk("R5", int'(z_out), tn(s_hh[k], x, y, n));
                if (p == n) chk("R6", int'(z_out), tn(s_ll[k], x, y, n));
                if (y == n) chk("R8", int'(z_out), x);
                if (x == n) chk("R8", int'(z_out), y);
                if (md >= 2) chk("R4", int'(z_out), model(y, x, p, n, md, k));
                if (x == 0 || y == 0) chk("R9", int'(z_out), 0);
            end
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_miss++;
            $display("FAIL watchdog R1 actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        int pa[6] = '{0, 1, 5, 8, 14, 15};
        int pb[3] = '{0, 4, 10};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset", int'(z_out), 0);
        rst = 1'b0;

        for (int i = 0; i < 6; i++)
            for (int md = 0; md < 4; md++)
                for (int k = 0; k < 6; k++)
                    sweep(15, pa[i], md, k);

        for (int i = 0; i < 3; i++)
            for (int md = 0; md < 4; md += 3)
                for (int k = 0; k < 6; k++)
                    sweep(10, pb[i], md, k);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule